// File: doc/BRIEF.md
# Tag Single-Block Write Controller

This block is the tag-side engine that carries out a single-block write request in a contactless memory tag. It receives the downlink as bits that have already been decoded, each marked by a bit-valid strobe, followed by a separate frame-end strobe. From this stream it extracts the command code, the target block, the requested lock bit and 32 data bits. It also checks a trailing 16-bit CRC. Depending on a configuration bit, that CRC is either required or optional.

Once a frame is accepted, the controller applies its checks in a fixed order. It first tests the CRC. It then reads the stored attributes of the block and applies the lock and password rules. If all checks pass, it issues one write to a simple synchronous memory port. It then waits for a programmable number of clock cycles, which stands for the programming time, and reads the block back to verify it. The result is a one-cycle response: an all-zero code means a bare start-of-frame, and a single set bit names the error.

Top module: `blkwr_ctrl`

## Requirements
- R1: A frame is the 4-bit command 0001, a 6-bit block number, a pad bit that must be 0, the lock bit, and 32 data bits, each field MSB first; a successful write stores exactly that data and lock bit at that block.
- R2: A frame is ignored if its command differs from 0001, if its pad bit is 1, or if it holds neither 44 nor 60 bits in total (44 without a CRC, 60 with one). An ignored frame causes no response and no memory access.
- R3: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed MSB first over the 40 bits after the command. On a mismatch the controller returns code 0010 one cycle after frame end and performs no memory access.
- R4: When cfg_crc_required is 1, a frame without a CRC gets code 0010. When it is 0, a frame without a CRC proceeds to programming.
- R5: A frame that arrives while tag_selected is 0 is ignored: no response and no memory access.
- R6: If the block's stored lock bit is 1, the controller returns code 0001 three cycles after frame end and issues no write.
- R7: If the block is password protected and login_write_ok is 0, the controller returns code 0100 three cycles after frame end and issues no write. With login_write_ok at 1 the write proceeds.
- R8: An accepted write produces exactly one memory write. It then waits PROG_CYCLES cycles, reads the block back, and responds with code 0000 at 6+PROG_CYCLES cycles after frame end.
- R9: If the read-back data or lock bit differs from what was written, the controller returns code 1000. This happens only at the end of the full cycle, 6+PROG_CYCLES cycles after frame end.
- R10: When several faults apply, CRC takes precedence over lock, and lock takes precedence over password. Each response code has at most one bit set.
- R11: A frame that completes while a command is still in progress is ignored.
- R12: After reset, rsp_valid is 0 and no memory access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_vld | input | 1 | Downlink bit strobe |
| rx_bit | input | 1 | Downlink bit value |
| rx_frame_end | input | 1 | Frame-end strobe, in a cycle after the last bit |
| cfg_crc_required | input | 1 | 1: CRC mandatory, 0: CRC optional |
| tag_selected | input | 1 | Tag is in the selected state |
| login_write_ok | input | 1 | A write login has succeeded |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 6 | Block number |
| mem_wdata | output | 32 | Write data |
| mem_wlock | output | 1 | Lock bit to write |
| mem_rdata | input | 32 | Read data, one cycle after a read |
| mem_rlock | input | 1 | Stored lock bit, one cycle after a read |
| mem_rprot | input | 1 | Block is password protected, one cycle after a read |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 4 | Error code: bit0 lock, bit1 CRC, bit2 password, bit3 verify; 0 = success |

## Verification
The response time depends on which check ends the command. A CRC fault or a missing mandatory CRC answers 1 cycle after the clock edge that samples frame end. A lock or password fault answers after 3 cycles, once the attribute read returns. Success and verify faults answer after 6+PROG_CYCLES cycles. The driver records the edge that samples each frame end and queues the code and latency it expects. The monitor samples on falling edges and compares both the code and the exact cycle distance. For ignored frames, the bench watches a fixed quiet window for any response and inspects the bench-side memory for writes.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    localparam int CMD_W        = 4;
    localparam int ADDR_W       = 6;
    localparam int DATA_W       = 32;
    localparam int CRC_W        = 16;
    localparam int PAYLOAD_BITS = ADDR_W + 2 + DATA_W;
    localparam int FRAME_SHORT  = CMD_W + PAYLOAD_BITS;
    localparam int FRAME_LONG   = FRAME_SHORT + CRC_W;

    localparam logic [CMD_W-1:0] CMD_WRITE = 4'b0001;
    localparam logic [CRC_W-1:0] CRC_POLY  = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_SEED  = 16'hFFFF;

    // Packed so that verify lands on bit 3 and lock on bit 0.
    typedef struct packed {
        logic verify;
        logic pwd;
        logic crc;
        logic lock;
    } err_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              lock;
        logic [DATA_W-1:0] data;
        logic              has_crc;
        logic              crc_ok;
    } frame_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ATTR,
        S_CHECK,
        S_WRITE,
        S_WAIT,
        S_VRD,
        S_VCMP
    } state_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        return {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ b) ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/bwc_rx.sv
module bwc_rx
    import bwc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_vld,
    input  logic   bit_val,
    input  logic   frame_end,
    output logic   frm_vld,
    output frame_t frm
);

    localparam int CNT_W = $clog2(FRAME_LONG + 2);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(FRAME_SHORT);
    localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(FRAME_LONG);
    localparam logic [CNT_W-1:0] CNT_CMD   = CNT_W'(CMD_W);

    logic [FRAME_LONG-1:0]  sr;
    logic [CNT_W-1:0]       cnt;
    logic [CRC_W-1:0]       crc;
    logic [FRAME_SHORT-1:0] head;
    logic                   is_short, is_long, accept;
    frame_t                 dec;

    always_comb begin
        is_short = (cnt == CNT_SHORT);
        is_long  = (cnt == CNT_LONG);
        head     = is_long ? sr[FRAME_LONG-1:CRC_W] : sr[FRAME_SHORT-1:0];
        accept   = (is_short || is_long)
                && (head[FRAME_SHORT-1 -: CMD_W] == CMD_WRITE)
                && !head[DATA_W+1];
        dec.addr    = head[PAYLOAD_BITS-1 -: ADDR_W];
        dec.lock    = head[DATA_W];
        dec.data    = head[DATA_W-1:0];
        dec.has_crc = is_long;
        dec.crc_ok  = is_long && (crc == sr[CRC_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            cnt     <= '0;
            crc     <= CRC_SEED;
            frm_vld <= 1'b0;
            frm     <= '0;
        end else begin
            frm_vld <= 1'b0;
            if (frame_end) begin
                cnt <= '0;
                crc <= CRC_SEED;
                if (accept) begin
                    frm_vld <= 1'b1;
                    frm     <= dec;
                end
            end else if (bit_vld) begin
                sr <= {sr[FRAME_LONG-2:0], bit_val};
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                if (cnt >= CNT_CMD && cnt < CNT_SHORT) crc <= crc_step(crc, bit_val);
            end
        end
    end

    // R3: the CRC register is frozen once the payload has been consumed
    a_r3_crc_frozen: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !frame_end && cnt >= CNT_SHORT) |=> $stable(crc));

    // R2: a frame of a length other than 44 or 60 never produces a strobe
    a_r2_bad_length: assert property (@(posedge clk) disable iff (rst)
        (frame_end && cnt != CNT_SHORT && cnt != CNT_LONG) |=> !frm_vld);

endmodule

// File: rtl/bwc_timer.sv
module bwc_timer #(
    parameter int CYCLES = 600000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);

    localparam int TW = $clog2(CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

    logic [TW-1:0] cnt;
    logic          run;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == LAST) run <= 1'b0;
            else             cnt <= cnt + 1'b1;
        end
    end

    // R8: the programming window never exceeds its configured length
    a_r8_timer_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= LAST));

endmodule

// File: rtl/blkwr_ctrl.sv
module blkwr_ctrl
    import bwc_pkg::*;
#(
    parameter int PROG_CYCLES = 600000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit_vld,
    input  logic              rx_bit,
    input  logic              rx_frame_end,
    input  logic              cfg_crc_required,
    input  logic              tag_selected,
    input  logic              login_write_ok,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wlock,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rlock,
    input  logic              mem_rprot,
    output logic              rsp_valid,
    output logic [3:0]        rsp_code
);

    state_e            state;
    logic              frm_vld;
    frame_t            frm;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;
    logic              cur_lock;
    err_t              rsp_err;
    logic              prog_done;
    logic              crc_fault;

    bwc_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (rx_bit_vld),
        .bit_val   (rx_bit),
        .frame_end (rx_frame_end),
        .frm_vld   (frm_vld),
        .frm       (frm)
    );

    bwc_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (state == S_WRITE),
        .done  (prog_done)
    );

    always_comb begin
        crc_fault = frm.has_crc ? !frm.crc_ok : cfg_crc_required;
        mem_en    = (state == S_ATTR) || (state == S_WRITE) || (state == S_VRD);
        mem_we    = (state == S_WRITE);
        mem_addr  = cur_addr;
        mem_wdata = cur_data;
        mem_wlock = cur_lock;
        rsp_code  = rsp_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur_addr  <= '0;
            cur_data  <= '0;
            cur_lock  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= '0;
            unique case (state)
                S_IDLE: begin
                    if (frm_vld && tag_selected) begin
                        cur_addr <= frm.addr;
                        cur_data <= frm.data;
                        cur_lock <= frm.lock;
                        if (crc_fault) begin
                            rsp_valid   <= 1'b1;
                            rsp_err.crc <= 1'b1;
                        end else begin
                            state <= S_ATTR;
                        end
                    end
                end
                S_ATTR:  state <= S_CHECK;
                S_CHECK: begin
                    if (mem_rlock) begin
                        rsp_valid    <= 1'b1;
                        rsp_err.lock <= 1'b1;
                        state        <= S_IDLE;
                    end else if (mem_rprot && !login_write_ok) begin
                        rsp_valid   <= 1'b1;
                        rsp_err.pwd <= 1'b1;
                        state       <= S_IDLE;
                    end else begin
                        state <= S_WRITE;
                    end
                end
                S_WRITE: state <= S_WAIT;
                S_WAIT:  if (prog_done) state <= S_VRD;
                S_VRD:   state <= S_VCMP;
                S_VCMP: begin
                    rsp_valid      <= 1'b1;
                    rsp_err.verify <= (mem_rdata != cur_data) || (mem_rlock != cur_lock);
                    state          <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R3: a bad CRC answers on the next cycle and leaves memory untouched
    a_r3_crc_abort: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && frm_vld && tag_selected && frm.has_crc && !frm.crc_ok)
        |=> (rsp_valid && rsp_code == 4'b0010 && !mem_en));

    // R5: an unselected tag neither answers nor moves
    a_r5_unselected: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && frm_vld && !tag_selected) |=> (state == S_IDLE && !rsp_valid));

    // R6: a stored lock bit prevents any following write
    a_r6_lock_no_write: assert property (@(posedge clk) disable iff (rst)
        (state == S_CHECK && mem_rlock) |=> !mem_we);

    // R8: a write strobe lasts exactly one cycle
    a_r8_single_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R10: at most one error bit per response
    a_r10_onehot_code: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0(rsp_code));

    // R11: a frame that lands mid-command leaves the target block unchanged
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && frm_vld) |=> $stable(cur_addr));

endmodule

// File: tb/blkwr_ctrl_tb_top.sv
module blkwr_ctrl_tb_top;

    localparam int P       = 60;
    localparam int LAT_CRC = 1;
    localparam int LAT_ATT = 3;
    localparam int LAT_PRG = 6 + P;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_bit_vld, rx_bit, rx_frame_end;
    logic        cfg_crc_required, tag_selected, login_write_ok;
    logic        mem_en, mem_we, mem_wlock;
    logic [5:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_rlock, mem_rprot;
    logic        rsp_valid;
    logic [3:0]  rsp_code;

    always #5 clk = ~clk;

    blkwr_ctrl #(.PROG_CYCLES(P)) dut_i (
        .clk(clk), .rst(rst),
        .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit), .rx_frame_end(rx_frame_end),
        .cfg_crc_required(cfg_crc_required), .tag_selected(tag_selected),
        .login_write_ok(login_write_ok),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wlock(mem_wlock),
        .mem_rdata(mem_rdata), .mem_rlock(mem_rlock), .mem_rprot(mem_rprot),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code)
    );

    // ---------------- memory model ----------------
    logic [31:0] m_data [64];
    logic        m_lock [64];
    logic        m_prot [64];
    logic        m_bad  [64];
    int          wr_count;
    int          cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) begin
                m_data[i] <= 32'h0;
                m_lock[i] <= 1'b0;
            end
            wr_count  <= 0;
            mem_rdata <= 32'h0;
            mem_rlock <= 1'b0;
            mem_rprot <= 1'b0;
        end else if (mem_en) begin
            if (mem_we) begin
                m_data[mem_addr] <= m_bad[mem_addr] ? (mem_wdata ^ 32'h1) : mem_wdata;
                m_lock[mem_addr] <= mem_wlock;
                wr_count         <= wr_count + 1;
            end else begin
                mem_rdata <= m_data[mem_addr];
                mem_rlock <= m_lock[mem_addr];
                mem_rprot <= m_prot[mem_addr];
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [3:0] code;
        int         ref_cyc;
        int         lat;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   rsp_seen = 0;
    int   last_fe = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            rsp_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected response (R2/R5/R11)", longint'(rsp_code), 64'hF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_code == e.code, {e.tag, " code"}, longint'(rsp_code), longint'(e.code));
                check(cyc - e.ref_cyc == e.lat, {e.tag, " latency"},
                      longint'(cyc - e.ref_cyc), longint'(e.lat));
            end
        end
    end

    // ---------------- driver ----------------
    function automatic logic [15:0] ref_crc(input logic [39:0] p);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 39; i >= 0; i--) begin
            if (c[15] ^ p[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    task automatic send_bits(input logic [59:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            rx_bit_vld = 1'b1;
            rx_bit     = bits[i];
        end
        @(negedge clk);
        rx_bit_vld   = 1'b0;
        rx_frame_end = 1'b1;
        last_fe      = cyc + 1;
        @(negedge clk);
        rx_frame_end = 1'b0;
    endtask

    // mode 0: no CRC, 1: correct CRC, 2: corrupted CRC
    task automatic send_write(input logic [3:0] cmd, input logic [5:0] addr, input logic lock,
                              input logic [31:0] data, input int mode);
        logic [43:0] head;
        logic [15:0] c;
        head = {cmd, addr, 1'b0, lock, data};
        c    = ref_crc(head[39:0]);
        if (mode == 2) c = c ^ 16'h0100;
        if (mode == 0) send_bits({16'h0, head}, 44);
        else           send_bits({head, c}, 60);
    endtask

    task automatic expect_rsp(input logic [3:0] code, input int lat, input string tag);
        exp_t e;
        e.code    = code;
        e.ref_cyc = last_fe;
        e.lat     = lat;
        e.tag     = tag;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_quiet(input string tag);
        int base;
        base = rsp_seen;
        repeat (100) @(negedge clk);
        check(rsp_seen == base, tag, longint'(rsp_seen - base), 64'h0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int w0;
        for (int i = 0; i < 64; i++) begin
            m_prot[i] = 1'b0;
            m_bad[i]  = 1'b0;
        end
        m_prot[9]  = 1'b1;
        m_bad[12]  = 1'b1;
        rst = 1'b1;
        rx_bit_vld = 1'b0; rx_bit = 1'b0; rx_frame_end = 1'b0;
        cfg_crc_required = 1'b0; tag_selected = 1'b1; login_write_ok = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: quiet after reset
        check(!rsp_valid && !mem_en, "R12 reset state", longint'({rsp_valid, mem_en}), 64'h0);

        // R1 R4 R8: no CRC, optional mode, plain write
        send_write(4'b0001, 6'd5, 1'b0, 32'hA5C3_0F17, 0);
        expect_rsp(4'b0000, LAT_PRG, "R4/R8 write without CRC");
        drain();
        check(m_data[5] == 32'hA5C3_0F17, "R1 stored data", longint'(m_data[5]), 64'hA5C30F17);
        check(wr_count == 1, "R8 single write", longint'(wr_count), 64'h1);

        // R1 R3: correct CRC, set lock bit
        send_write(4'b0001, 6'd6, 1'b1, 32'h1234_5678, 1);
        expect_rsp(4'b0000, LAT_PRG, "R3 good CRC write");
        drain();
        check(m_lock[6] == 1'b1 && m_data[6] == 32'h1234_5678, "R1 stored lock",
              longint'({m_lock[6], m_data[6]}), 64'h112345678);

        // R6: locked block
        w0 = wr_count;
        send_write(4'b0001, 6'd6, 1'b0, 32'hFFFF_0000, 1);
        expect_rsp(4'b0001, LAT_ATT, "R6 locked block");
        drain();
        check(wr_count == w0 && m_data[6] == 32'h1234_5678, "R6 no write",
              longint'(wr_count - w0), 64'h0);

        // R3: corrupted CRC
        w0 = wr_count;
        send_write(4'b0001, 6'd7, 1'b0, 32'hDEAD_BEEF, 2);
        expect_rsp(4'b0010, LAT_CRC, "R3 CRC mismatch");
        drain();
        check(wr_count == w0 && m_data[7] == 32'h0, "R3 no write", longint'(m_data[7]), 64'h0);

        // R4: mandatory CRC
        cfg_crc_required = 1'b1;
        send_write(4'b0001, 6'd8, 1'b0, 32'h0000_00FF, 0);
        expect_rsp(4'b0010, LAT_CRC, "R4 missing mandatory CRC");
        drain();
        check(m_data[8] == 32'h0, "R4 no write", longint'(m_data[8]), 64'h0);
        send_write(4'b0001, 6'd8, 1'b0, 32'h0000_00FF, 1);
        expect_rsp(4'b0000, LAT_PRG, "R4 mandatory CRC present");
        drain();
        check(m_data[8] == 32'hFF, "R4 written", longint'(m_data[8]), 64'hFF);
        cfg_crc_required = 1'b0;

        // R7: password protection
        send_write(4'b0001, 6'd9, 1'b1, 32'hCAFE_F00D, 1);
        expect_rsp(4'b0100, LAT_ATT, "R7 no login");
        drain();
        check(m_data[9] == 32'h0, "R7 no write", longint'(m_data[9]), 64'h0);
        login_write_ok = 1'b1;
        send_write(4'b0001, 6'd9, 1'b1, 32'hCAFE_F00D, 1);
        expect_rsp(4'b0000, LAT_PRG, "R7 with login");
        drain();
        check(m_data[9] == 32'hCAFE_F00D, "R7 written", longint'(m_data[9]), 64'hCAFEF00D);
        login_write_ok = 1'b0;

        // R10: priorities
        send_write(4'b0001, 6'd9, 1'b0, 32'h1, 1);
        expect_rsp(4'b0001, LAT_ATT, "R10 lock over password");
        drain();
        send_write(4'b0001, 6'd6, 1'b0, 32'h2, 2);
        expect_rsp(4'b0010, LAT_CRC, "R10 CRC over lock");
        drain();

        // R9: verify failure after full cycle
        send_write(4'b0001, 6'd12, 1'b0, 32'h0F0F_0F0E, 1);
        expect_rsp(4'b1000, LAT_PRG, "R9 verify mismatch");
        drain();

        // R5: not selected
        w0 = wr_count;
        tag_selected = 1'b0;
        send_write(4'b0001, 6'd13, 1'b0, 32'h5555_AAAA, 1);
        expect_quiet("R5 unselected no response");
        check(wr_count == w0 && m_data[13] == 32'h0, "R5 no write", longint'(m_data[13]), 64'h0);
        tag_selected = 1'b1;

        // R2: wrong command, wrong length
        send_write(4'b0010, 6'd14, 1'b0, 32'h7777_7777, 1);
        expect_quiet("R2 wrong command ignored");
        send_bits({10'h0, 4'b0001, 6'd14, 1'b0, 1'b0, 32'h7777_7777, 6'h0}, 50);
        expect_quiet("R2 wrong length ignored");
        check(m_data[14] == 32'h0, "R2 no write", longint'(m_data[14]), 64'h0);

        // R11: second frame during programming
        w0 = wr_count;
        send_write(4'b0001, 6'd20, 1'b0, 32'h2020_2020, 0);
        expect_rsp(4'b0000, LAT_PRG, "R11 first command");
        send_write(4'b0001, 6'd21, 1'b0, 32'h2121_2121, 0);
        drain();
        expect_quiet("R11 busy frame no response");
        check(wr_count == w0 + 1 && m_data[21] == 32'h0 && m_data[20] == 32'h2020_2020,
              "R11 busy frame ignored", longint'(m_data[21]), 64'h0);

        check(exp_q.size() == 0, "R8 all responses seen", longint'(exp_q.size()), 64'h0);
        summary();
        $finish;
    end

endmodule